// File: doc/BRIEF.md
# Octant Trigger Count Summer

This block gathers one summary record from each of the ten sectors of an octant (ten slices of 4.5 degrees, 45 degrees in all). It adds the records into one set of event-level counts for the trigger term logic downstream. Each record carries an event tag, sixteen track-type counts and a hit count. The sixteen track-type counts are the four momentum bins, each split four ways. The block produces sixteen track-type sums and one octant hit total.

Records arrive per sector, in any cycle and in any order. Each sector holds its record until the other nine are present. The block then compares the tags. If the tags agree, it presents the seventeen sums once, as a one-cycle pulse. The same result goes out on two output ports so that two consumers can be fed without external splitting. If the tags disagree, the event is dropped and an error pulse is raised. Each sum clamps at its largest code instead of wrapping. New records are taken again in the cycle the result appears.

Top module: `octant_sum`

## Requirements
- R1: After reset both ports show all sums at zero with valid low, the error flag is low, and every sector ready bit is high.
- R2: A sector record is captured when its valid and ready bits are both high, and that sector's ready then drops. While ready is low, further records offered to that sector are ignored, and the captured record is the one summed.
- R3: Two clock edges after the tenth record is captured, the valid bit is high and the outputs carry the sums of all ten captured records, provided all ten tags are equal. The first edge marks the slots full and the second registers the result.
- R4: Record layout per sector: count field k occupies bits [k*CW +: CW] of that sector's count slice, with k = bin*4 + kind (kind 0 all tracks, 1 clustered, 2 isolated, 3 isolated and clustered). Output sum k occupies bits [k*SW +: SW].
- R5: A track-type sum whose true value exceeds 2^SW-1 is presented as 2^SW-1.
- R6: The hit total clamps at 2^HSW-1 in the same way.
- R7: If any captured tag differs from the others, the error flag pulses for one cycle in place of valid. The sums on both ports keep their previous values.
- R8: Both output ports always carry identical sums, hit totals and valid bits.
- R9: Valid is a single-cycle pulse, and the sums hold their value until the next completed event.
- R10: In the cycle after all ten slots fill, every ready bit is low. In the cycle valid or error is high, every ready bit is high again, so the next event's records are accepted immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_vld | input | NSEC | Per-sector record offer |
| sec_tag | input | NSEC*TW | Per-sector event tag |
| sec_cnt | input | NSEC*16*CW | Per-sector sixteen track-type counts |
| sec_hit | input | NSEC*HW | Per-sector hit count |
| sec_rdy | output | NSEC | Per-sector slot free |
| a_sum | output | 16*SW | Port A track-type sums |
| a_hit | output | HSW | Port A octant hit total |
| a_vld | output | 1 | Port A result pulse |
| b_sum | output | 16*SW | Port B track-type sums |
| b_hit | output | HSW | Port B octant hit total |
| b_vld | output | 1 | Port B result pulse |
| tag_err | output | 1 | Tag mismatch pulse |

## Verification
A slot that latches the wrong record, or takes a second offer while full, shows up two cycles later as a wrong sum on the next valid pulse. The bench makes this visible by changing the second offer's values. A stuck fill flag shows in the ready bits in the very next cycle: one sector stays low after a result, or the valid pulse never comes. A broken clamp or a lost carry in the adder shows as a wrapped small value on the first all-maximum event. A faulty tag comparator either pulses error on good events or updates the sums on bad ones, and either is visible in the same cycle as the pulse.

// File: rtl/ocs_pkg.sv
package ocs_pkg;
   localparam int unsigned OCS_NBIN  = 4;
   localparam int unsigned OCS_NKIND = 4;
   localparam int unsigned OCS_NCAT  = OCS_NBIN * OCS_NKIND;

   typedef enum logic [1:0] {
      KIND_ALL     = 2'd0,
      KIND_CLUS    = 2'd1,
      KIND_ISO     = 2'd2,
      KIND_ISOCLUS = 2'd3
   } ocs_kind_e;
endpackage

// File: rtl/ocs_slot.sv
module ocs_slot #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         clear,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         full
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         dout <= '0;
      end else if (clear) begin
         full <= 1'b0;
      end else if (load) begin
         full <= 1'b1;
         dout <= din;
      end
   end
endmodule

// File: rtl/ocs_satsum.sv
module ocs_satsum #(
   parameter int unsigned N  = 10,
   parameter int unsigned IW = 4,
   parameter int unsigned OW = 6
) (
   input  logic [N*IW-1:0] terms,
   output logic [OW-1:0]   sum
);
   localparam int unsigned GW = $clog2(N);
   localparam int unsigned FW = IW + GW;

   if (N < 2) begin : g_bad_n
      $error("ocs_satsum: N must be at least 2");
   end

   logic [FW-1:0] acc;

   always_comb begin
      acc = '0;
      for (int i = 0; i < N; i++) begin
         acc = acc + {{GW{1'b0}}, terms[i*IW +: IW]};
      end
   end

   if (OW >= FW) begin : g_wide
      assign sum = OW'(acc);
   end else begin : g_clamp
      localparam logic [FW-1:0] LIM = {{(FW-OW){1'b0}}, {OW{1'b1}}};
      assign sum = (acc > LIM) ? {OW{1'b1}} : acc[OW-1:0];
   end
endmodule

// File: rtl/ocs_tagchk.sv
module ocs_tagchk #(
   parameter int unsigned N  = 10,
   parameter int unsigned TW = 4
) (
   input  logic [N*TW-1:0] tags,
   output logic            same
);
   always_comb begin
      same = 1'b1;
      for (int i = 1; i < N; i++) begin
         if (tags[i*TW +: TW] != tags[TW-1:0]) same = 1'b0;
      end
   end
endmodule

// File: rtl/ocs_outreg.sv
module ocs_outreg #(
   parameter int unsigned SUMW = 96,
   parameter int unsigned HSW  = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld,
   input  logic [SUMW-1:0] sum_d,
   input  logic [HSW-1:0]  hit_d,
   output logic [SUMW-1:0] sum_q,
   output logic [HSW-1:0]  hit_q,
   output logic            vld_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
         hit_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= ld;
         if (ld) begin
            sum_q <= sum_d;
            hit_q <= hit_d;
         end
      end
   end
endmodule

// File: rtl/octant_sum.sv
module octant_sum
   import ocs_pkg::*;
#(
   parameter int unsigned NSEC      = 10,
   parameter int unsigned CW        = 4,
   parameter int unsigned SW        = 6,
   parameter int unsigned HW        = 6,
   parameter int unsigned HSW       = 9,
   parameter int unsigned TW        = 4,
   parameter bit          SPLIT_OUT = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NSEC-1:0]          sec_vld,
   input  logic [NSEC*TW-1:0]       sec_tag,
   input  logic [NSEC*OCS_NCAT*CW-1:0] sec_cnt,
   input  logic [NSEC*HW-1:0]       sec_hit,
   output logic [NSEC-1:0]          sec_rdy,
   output logic [OCS_NCAT*SW-1:0]   a_sum,
   output logic [HSW-1:0]           a_hit,
   output logic                     a_vld,
   output logic [OCS_NCAT*SW-1:0]   b_sum,
   output logic [HSW-1:0]           b_hit,
   output logic                     b_vld,
   output logic                     tag_err
);
   localparam int unsigned CNTW = OCS_NCAT * CW;
   localparam int unsigned RECW = TW + CNTW + HW;
   localparam int unsigned SUMW = OCS_NCAT * SW;

   if (NSEC < 2) begin : g_bad_nsec
      $error("octant_sum: NSEC must be at least 2");
   end
   if (SW < CW || HSW < HW) begin : g_bad_width
      $error("octant_sum: sum widths must not be narrower than field widths");
   end
   if (TW < 1) begin : g_bad_tag
      $error("octant_sum: TW must be at least 1");
   end

   logic [NSEC-1:0]    full;
   logic [NSEC-1:0]    take;
   logic [RECW-1:0]    rec_q [NSEC];
   logic [NSEC*TW-1:0] tag_flat;
   logic [NSEC*HW-1:0] hit_flat;
   logic               all_full;
   logic               tags_same;
   logic               done_ok;
   logic [SUMW-1:0]    sum_c;
   logic [HSW-1:0]     hit_c;

   assign all_full = &full;

   for (genvar s = 0; s < NSEC; s++) begin : g_sec
      assign sec_rdy[s] = ~full[s] & ~all_full;
      assign take[s]    = sec_vld[s] & sec_rdy[s];

      ocs_slot #(.W(RECW)) u_slot (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (take[s]),
         .clear (all_full),
         .din   ({sec_tag[s*TW +: TW], sec_cnt[s*CNTW +: CNTW], sec_hit[s*HW +: HW]}),
         .dout  (rec_q[s]),
         .full  (full[s])
      );

      assign tag_flat[s*TW +: TW] = rec_q[s][RECW-1 -: TW];
      assign hit_flat[s*HW +: HW] = rec_q[s][HW-1:0];
   end

   for (genvar k = 0; k < OCS_NCAT; k++) begin : g_cat
      logic [NSEC*CW-1:0] col;
      for (genvar s = 0; s < NSEC; s++) begin : g_col
         assign col[s*CW +: CW] = rec_q[s][HW + k*CW +: CW];
      end
      ocs_satsum #(.N(NSEC), .IW(CW), .OW(SW)) u_sum (
         .terms (col),
         .sum   (sum_c[k*SW +: SW])
      );
   end

   ocs_satsum #(.N(NSEC), .IW(HW), .OW(HSW)) u_hitsum (
      .terms (hit_flat),
      .sum   (hit_c)
   );

   ocs_tagchk #(.N(NSEC), .TW(TW)) u_tag (
      .tags (tag_flat),
      .same (tags_same)
   );

   assign done_ok = all_full & tags_same;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tag_err <= 1'b0;
      else        tag_err <= all_full & ~tags_same;
   end

   if (SPLIT_OUT) begin : g_split
      ocs_outreg #(.SUMW(SUMW), .HSW(HSW)) u_out_a (
         .clk (clk), .rst_n (rst_n), .ld (done_ok),
         .sum_d (sum_c), .hit_d (hit_c),
         .sum_q (a_sum), .hit_q (a_hit), .vld_q (a_vld)
      );
      ocs_outreg #(.SUMW(SUMW), .HSW(HSW)) u_out_b (
         .clk (clk), .rst_n (rst_n), .ld (done_ok),
         .sum_d (sum_c), .hit_d (hit_c),
         .sum_q (b_sum), .hit_q (b_hit), .vld_q (b_vld)
      );
   end else begin : g_shared
      ocs_outreg #(.SUMW(SUMW), .HSW(HSW)) u_out (
         .clk (clk), .rst_n (rst_n), .ld (done_ok),
         .sum_d (sum_c), .hit_d (hit_c),
         .sum_q (a_sum), .hit_q (a_hit), .vld_q (a_vld)
      );
      assign b_sum = a_sum;
      assign b_hit = a_hit;
      assign b_vld = a_vld;
   end
endmodule

// File: rtl/octant_sum_chk.sv
module octant_sum_chk
   import ocs_pkg::*;
#(
   parameter int unsigned NSEC = 10,
   parameter int unsigned CW   = 4,
   parameter int unsigned SW   = 6,
   parameter int unsigned HW   = 6,
   parameter int unsigned HSW  = 9,
   parameter int unsigned TW   = 4
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NSEC-1:0]             sec_vld,
   input logic [NSEC*TW-1:0]          sec_tag,
   input logic [NSEC*OCS_NCAT*CW-1:0] sec_cnt,
   input logic [NSEC*HW-1:0]          sec_hit,
   input logic [NSEC-1:0]             sec_rdy,
   input logic [OCS_NCAT*SW-1:0]      a_sum,
   input logic [HSW-1:0]              a_hit,
   input logic                        a_vld,
   input logic [OCS_NCAT*SW-1:0]      b_sum,
   input logic [HSW-1:0]              b_hit,
   input logic                        b_vld,
   input logic                        tag_err
);
   // R8: both consumers see the same result
   p_ports_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (a_sum == b_sum) && (a_hit == b_hit) && (a_vld == b_vld));

   // R9: the result strobe lasts one cycle
   p_vld_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      a_vld |=> !a_vld);

   // R9: sums only move together with a strobe
   p_sum_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !a_vld |-> ($stable(a_sum) && $stable(a_hit)));

   // R7: a mismatch never also reports a result
   p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(tag_err && a_vld));

   // R7: the error strobe lasts one cycle
   p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tag_err |=> !tag_err);

   // R10: result or error follows a cycle with every slot closed
   p_rdy_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (a_vld || tag_err) |-> ($past(sec_rdy) == '0));

   // R10: slots reopen in the result cycle
   p_rdy_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (a_vld || tag_err) |-> (sec_rdy == '1));
endmodule

bind octant_sum octant_sum_chk #(
   .NSEC (NSEC), .CW (CW), .SW (SW), .HW (HW), .HSW (HSW), .TW (TW)
) u_chk (.*);

// File: tb/octant_sum_tb.sv
module octant_sum_tb_top;
   localparam int NSEC = 10;
   localparam int NCAT = 16;
   localparam int CW   = 4;
   localparam int SW   = 6;
   localparam int HW   = 6;
   localparam int HSW  = 9;
   localparam int TW   = 4;
   localparam int NV   = 6;

   // vector table: count base, hit base, tag, bad sector (-1 none); base 255 = all max
   localparam int VB   [NV] = '{1, 7, 255, 3, 0, 12};
   localparam int VH   [NV] = '{2, 40, 255, 9, 0, 5};
   localparam int VT   [NV] = '{3, 8, 1, 6, 0, 15};
   localparam int VBAD [NV] = '{-1, -1, -1, 4, -1, 9};

   logic                      clk = 1'b0;
   logic                      rst_n = 1'b0;
   logic [NSEC-1:0]           sec_vld = '0;
   logic [NSEC*TW-1:0]        sec_tag = '0;
   logic [NSEC*NCAT*CW-1:0]   sec_cnt = '0;
   logic [NSEC*HW-1:0]        sec_hit = '0;
   logic [NSEC-1:0]           sec_rdy;
   logic [NCAT*SW-1:0]        a_sum, b_sum;
   logic [HSW-1:0]            a_hit, b_hit;
   logic                      a_vld, b_vld, tag_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [NCAT*SW-1:0] exp_sum;
   logic [HSW-1:0]     exp_hit;
   logic [NCAT*SW-1:0] last_sum = '0;
   logic [HSW-1:0]     last_hit = '0;

   always #10 clk = ~clk;

   octant_sum dut_i (
      .clk, .rst_n, .sec_vld, .sec_tag, .sec_cnt, .sec_hit, .sec_rdy,
      .a_sum, .a_hit, .a_vld, .b_sum, .b_hit, .b_vld, .tag_err
   );

   function automatic int fval(int b, int s, int k);
      return (b == 255) ? 15 : ((b * 3 + s + k * 5) % 16);
   endfunction

   function automatic int hval(int h, int s);
      return (h == 255) ? 63 : ((h + 7 * s) % 64);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic load_sector(int s, int b, int h, int tag);
      for (int k = 0; k < NCAT; k++) sec_cnt[(s*NCAT + k)*CW +: CW] = CW'(fval(b, s, k));
      sec_hit[s*HW +: HW] = HW'(hval(h, s));
      sec_tag[s*TW +: TW] = TW'(tag);
   endtask

   // R4/R5/R6: field k summed over sectors, clamped at the sum width maximum
   task automatic compute_exp(int b, int h);
      for (int k = 0; k < NCAT; k++) begin
         int acc = 0;
         for (int s = 0; s < NSEC; s++) acc += fval(b, s, k);
         exp_sum[k*SW +: SW] = (acc > 63) ? 6'd63 : SW'(acc);
      end
      begin
         int hacc = 0;
         for (int s = 0; s < NSEC; s++) hacc += hval(h, s);
         exp_hit = (hacc > 511) ? 9'd511 : HSW'(hacc);
      end
   endtask

   task automatic check_result(bit bad);
      if (bad) begin
         chk(tag_err == 1'b1, "R7 err pulse", 128'(tag_err), 128'd1);
         chk(a_vld == 1'b0, "R7 no valid", 128'(a_vld), 128'd0);
         chk(a_sum == last_sum, "R7 sums kept", 128'(a_sum), 128'(last_sum));
         chk(a_hit == last_hit, "R7 hit kept", 128'(a_hit), 128'(last_hit));
      end else begin
         chk(a_vld == 1'b1, "R3 valid", 128'(a_vld), 128'd1);
         chk(tag_err == 1'b0, "R3 no err", 128'(tag_err), 128'd0);
         chk(a_sum == exp_sum, "R3 R4 R5 sums", 128'(a_sum), 128'(exp_sum));
         chk(a_hit == exp_hit, "R3 R6 hit", 128'(a_hit), 128'(exp_hit));
         chk(b_sum == a_sum && b_hit == a_hit && b_vld == a_vld, "R8 port B",
             128'(b_sum), 128'(a_sum));
         last_sum = exp_sum;
         last_hit = exp_hit;
      end
      chk(sec_rdy == '1, "R10 reopen", 128'(sec_rdy), 128'(10'h3ff));
   endtask

   task automatic run_event(int b, int h, int tag, int bad);
      @(negedge clk);
      for (int s = 0; s < NSEC; s++) load_sector(s, b, h, (s == bad) ? (tag ^ 1) : tag);
      sec_vld = '1;
      compute_exp(b, h);
      @(negedge clk);
      sec_vld = '0;
      chk(sec_rdy == '0, "R10 closed", 128'(sec_rdy), 128'd0);
      @(negedge clk);
      check_result(bad >= 0);
      @(negedge clk);
      chk(a_vld == 1'b0 && tag_err == 1'b0, "R9 single pulse", 128'({a_vld, tag_err}), 128'd0);
      chk(a_sum == last_sum, "R9 hold", 128'(a_sum), 128'(last_sum));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(a_sum == '0 && a_hit == '0, "R1 sums zero", 128'(a_sum), 128'd0);
      chk(a_vld == 1'b0 && b_vld == 1'b0 && tag_err == 1'b0, "R1 flags low",
          128'({a_vld, b_vld, tag_err}), 128'd0);
      chk(sec_rdy == '1, "R1 ready", 128'(sec_rdy), 128'(10'h3ff));

      for (int v = 0; v < NV; v++) run_event(VB[v], VH[v], VT[v], VBAD[v]);

      // R2: staggered arrival, repeat offer to a full slot is ignored
      @(negedge clk);
      load_sector(0, 2, 11, 5);
      sec_vld = 10'b0000000001;
      @(negedge clk);
      chk(sec_rdy == 10'h3fe, "R2 slot closed", 128'(sec_rdy), 128'(10'h3fe));
      for (int s = 1; s < NSEC; s++) load_sector(s, 2, 11, 5);
      load_sector(0, 9, 30, 5);
      sec_vld = '1;
      compute_exp(2, 11);
      @(negedge clk);
      sec_vld = '0;
      chk(sec_rdy == '0, "R10 closed stagger", 128'(sec_rdy), 128'd0);
      @(negedge clk);
      check_result(1'b0);

      // R10: records offered in the result cycle start the next event
      for (int s = 0; s < NSEC; s++) load_sector(s, 5, 20, 2);
      sec_vld = '1;
      compute_exp(5, 20);
      @(negedge clk);
      sec_vld = '0;
      chk(a_vld == 1'b0, "R9 pulse ends", 128'(a_vld), 128'd0);
      chk(sec_rdy == '0, "R10 back to back closed", 128'(sec_rdy), 128'd0);
      @(negedge clk);
      check_result(1'b0);
      @(negedge clk);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule